// File: doc/BRIEF.md
# Predicated Contiguous Halfword Store Sequencer

This block carries out one predicated contiguous store of halfwords from a vector register. A single start pulse captures the vector value, a byte-granular predicate, a 64-bit base address, a stack-pointer-base flag, a signed 4-bit vector-multiple immediate and the container size code. The block then emits one 2-byte write request for each active element, in ascending element order, on a valid/ready write port. When the stream ends it pulses `done`.

The store is placed at `base + ((imm * elements) + e) * 2`, where `elements` is the vector width divided by the container width. The immediate therefore steps the store by whole vector footprints, whatever the predicate holds. For 32-bit and 64-bit containers only the low halfword of each element reaches memory. When the base comes from the stack pointer, the block raises a one-cycle alignment-check strobe. Tag checking is flagged for any other base.

Sequencer states: `ST_IDLE` waits for `start`. `ST_ISSUE` presents the lowest pending active element. `ST_FINISH` drives the one-cycle `done`. Transitions: IDLE→ISSUE on start with at least one active element; IDLE→FINISH on start with none active; ISSUE→ISSUE on an accepted write while others remain, or while `wr_ready` is low; ISSUE→FINISH when the last pending write is accepted; FINISH→IDLE always.

Top module: `pstore_seq`

## Requirements
- R1: Each write carries the low 16 bits of its element, `vec_in[e*esize +: 16]`. The size code maps 01 to esize 16, 10 to 32 and 11 to 64, and code 00 behaves as 01. The element count is VL/esize.
- R2: Element e is active when predicate bit `e*esize/8` is 1. An inactive element produces no write request.
- R3: The write address for element e is `base + ((imm*elements) + e) * 2`. Here `imm` is the two's-complement value of the 4-bit immediate (-8..7), and `elements` depends only on the size code.
- R4: Writes appear in ascending element order, one for each accepted valid/ready handshake.
- R5: While `wr_valid` is high and `wr_ready` is low, the request stays valid and the address and data hold their values.
- R6: `done` is high for exactly one cycle. That cycle follows the acceptance of the last write, or directly follows the start cycle when no element is active. It never coincides with `wr_valid`.
- R7: `start` is ignored while an operation is in progress (ISSUE or FINISH). Changed inputs during that time do not alter the stream, and no new operation begins after `done`.
- R8: `sp_align_chk` pulses for one cycle, in the cycle after start, when the stack-pointer flag is set and either some element is active or `empty_sp_chk` is set. Otherwise it stays low.
- R9: `tag_chk` is high from the cycle after start through the `done` cycle when the stack-pointer flag was clear at start. It is low otherwise and while idle.
- R10: Address arithmetic wraps modulo 2^64.
- R11: During and right after reset, `wr_valid`, `done`, `sp_align_chk` and `tag_chk` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches one store when idle |
| vec_in | input | VL | Source vector register value |
| pred_in | input | VL/8 | Byte-granular predicate |
| base_in | input | AW | Scalar base address |
| base_sp | input | 1 | Base is the stack pointer |
| imm_in | input | 4 | Signed vector-multiple offset |
| size_code | input | 2 | Container size: 01=16, 10=32, 11=64 bits |
| empty_sp_chk | input | 1 | Request the alignment check even with no active element |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | AW | Byte address of the halfword |
| wr_data | output | 16 | Halfword to store |
| done | output | 1 | One-cycle completion pulse |
| sp_align_chk | output | 1 | Stack-pointer alignment check strobe |
| tag_chk | output | 1 | Tag checking enabled for this store |

## Verification
The bench builds the block with VL = 64, so the predicate is 8 bits wide and holds at most four elements. At that size every predicate pattern can be swept for each of the three container sizes. The bench covers the empty predicate and the full one, all sixteen immediates, and address wrap at both ends of the 64-bit space. Backpressure patterns vary the ready timing. A start held over into the busy period, with altered inputs, tests that the block ignores it.

// File: rtl/pstore_pkg.sv
`timescale 1ns/1ps
package pstore_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_t;

    localparam logic [1:0] SZC_H = 2'b01;
    localparam logic [1:0] SZC_W = 2'b10;
    localparam logic [1:0] SZC_D = 2'b11;

    // log2(esize/16): 0 for halfword containers, 1 for word, 2 for doubleword
    function automatic logic [1:0] size_shift(input logic [1:0] code);
        case (code)
            SZC_W:   return 2'd1;
            SZC_D:   return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/pstore_mask.sv
`timescale 1ns/1ps
// Turns a byte-granular predicate into one activity bit per element slot.
module pstore_mask #(
    parameter int VL = 128,
    localparam int PW = VL / 8,
    localparam int NE = VL / 16
) (
    input  logic [PW-1:0] pred,
    input  logic [1:0]    sh,
    output logic [NE-1:0] act
);
    logic [NE-1:0] a16, a32, a64;

    for (genvar e = 0; e < NE; e++) begin : g_slot
        assign a16[e] = pred[2*e];
        if (e < NE/2) begin : g_w
            assign a32[e] = pred[4*e];
        end else begin : g_wz
            assign a32[e] = 1'b0;
        end
        if (e < NE/4) begin : g_d
            assign a64[e] = pred[8*e];
        end else begin : g_dz
            assign a64[e] = 1'b0;
        end
    end

    always_comb begin
        unique case (sh)
            2'd1:    act = a32;
            2'd2:    act = a64;
            default: act = a16;
        endcase
    end
endmodule

// File: rtl/pstore_pick.sv
`timescale 1ns/1ps
// Lowest set bit finder.
module pstore_pick #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) idx = IW'(i);
        end
        any = |pend;
    end
endmodule

// File: rtl/pstore_addr.sv
`timescale 1ns/1ps
// base + ((imm * elements) + idx) * 2, modulo 2^AW.
module pstore_addr #(
    parameter int AW = 64,
    parameter int NE = 8,
    localparam int IW = $clog2(NE),
    localparam int LOG_NE = $clog2(NE)
) (
    input  logic [AW-1:0] base,
    input  logic [3:0]    imm,
    input  logic [1:0]    sh,
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] imm_ext;
    logic [AW-1:0] scaled;
    logic [AW-1:0] eoff;
    logic [7:0]    amt;

    always_comb begin
        imm_ext = {{(AW-4){imm[3]}}, imm};
        amt     = 8'(LOG_NE) - {6'd0, sh};
        scaled  = imm_ext << amt;
        eoff    = scaled + AW'(idx);
        addr    = base + {eoff[AW-2:0], 1'b0};
    end
endmodule

// File: rtl/pstore_lane.sv
`timescale 1ns/1ps
// Picks the low halfword of the selected element for the active container size.
module pstore_lane #(
    parameter int VL = 128,
    localparam int NE = VL / 16,
    localparam int IW = $clog2(NE)
) (
    input  logic [VL-1:0] vec,
    input  logic [IW-1:0] idx,
    input  logic [1:0]    sh,
    output logic [15:0]   data
);
    logic [15:0] h16 [NE];
    logic [15:0] h32 [NE];
    logic [15:0] h64 [NE];

    for (genvar e = 0; e < NE; e++) begin : g_el
        assign h16[e] = vec[e*16 +: 16];
        if (e < NE/2) begin : g_w
            assign h32[e] = vec[e*32 +: 16];
        end else begin : g_wz
            assign h32[e] = '0;
        end
        if (e < NE/4) begin : g_d
            assign h64[e] = vec[e*64 +: 16];
        end else begin : g_dz
            assign h64[e] = '0;
        end
    end

    always_comb begin
        unique case (sh)
            2'd1:    data = h32[idx];
            2'd2:    data = h64[idx];
            default: data = h16[idx];
        endcase
    end
endmodule

// File: rtl/pstore_seq.sv
`timescale 1ns/1ps
module pstore_seq #(
    parameter int VL = 128,
    parameter int AW = 64,
    localparam int PW = VL / 8,
    localparam int NE = VL / 16,
    localparam int IW = $clog2(NE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [VL-1:0] vec_in,
    input  logic [PW-1:0] pred_in,
    input  logic [AW-1:0] base_in,
    input  logic          base_sp,
    input  logic [3:0]    imm_in,
    input  logic [1:0]    size_code,
    input  logic          empty_sp_chk,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [15:0]   wr_data,
    output logic          done,
    output logic          sp_align_chk,
    output logic          tag_chk
);
    import pstore_pkg::*;

    seq_state_t    state_q, state_d;
    logic [VL-1:0] vec_q;
    logic [AW-1:0] base_q;
    logic [3:0]    imm_q;
    logic [1:0]    sh_q;
    logic          sp_q;
    logic          align_q;
    logic [NE-1:0] pend_q, pend_d;

    logic [1:0]    sh_in;
    logic [NE-1:0] act_in;
    logic [IW-1:0] cur_idx;
    logic          pend_any;
    logic [NE-1:0] pend_rest;
    logic          launch;
    logic          accept;

    assign sh_in = size_shift(size_code);

    pstore_mask #(.VL(VL)) u_mask (
        .pred (pred_in),
        .sh   (sh_in),
        .act  (act_in)
    );

    pstore_pick #(.N(NE)) u_pick (
        .pend (pend_q),
        .idx  (cur_idx),
        .any  (pend_any)
    );

    pstore_addr #(.AW(AW), .NE(NE)) u_addr (
        .base (base_q),
        .imm  (imm_q),
        .sh   (sh_q),
        .idx  (cur_idx),
        .addr (wr_addr)
    );

    pstore_lane #(.VL(VL)) u_lane (
        .vec  (vec_q),
        .idx  (cur_idx),
        .sh   (sh_q),
        .data (wr_data)
    );

    assign launch    = (state_q == ST_IDLE) && start;
    assign accept    = (state_q == ST_ISSUE) && wr_ready;
    assign pend_rest = pend_q & ~(NE'(1) << cur_idx);

    // next state and pending mask
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    pend_d  = act_in;
                    state_d = (|act_in) ? ST_ISSUE : ST_FINISH;
                end
            end
            ST_ISSUE: begin
                if (wr_ready) begin
                    pend_d = pend_rest;
                    if (!(|pend_rest)) state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            vec_q   <= '0;
            base_q  <= '0;
            imm_q   <= '0;
            sh_q    <= '0;
            sp_q    <= 1'b0;
            align_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            align_q <= launch && base_sp && ((|act_in) || empty_sp_chk);
            if (launch) begin
                vec_q  <= vec_in;
                base_q <= base_in;
                imm_q  <= imm_in;
                sh_q   <= sh_in;
                sp_q   <= base_sp;
            end
        end
    end

    // outputs
    always_comb begin
        wr_valid     = 1'b0;
        done         = 1'b0;
        tag_chk      = 1'b0;
        sp_align_chk = align_q;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ISSUE: begin
                wr_valid = pend_any;
                tag_chk  = !sp_q;
            end
            ST_FINISH: begin
                done    = 1'b1;
                tag_chk = !sp_q;
            end
            default: ;
        endcase
    end

    logic unused_ok;
    assign unused_ok = accept;
endmodule

// File: rtl/pstore_seq_chk.sv
`timescale 1ns/1ps
module pstore_seq_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [AW-1:0] wr_addr,
    input logic [15:0]   wr_data,
    input logic          done,
    input logic          sp_align_chk,
    input logic          tag_chk
);
    // R5: stalled request holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done never overlaps a request
    p_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_valid);

    // R7: no request directly after done even with start held
    p_quiet_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wr_valid);

    // R8: alignment check is a single-cycle strobe
    p_align_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sp_align_chk |=> !sp_align_chk);

    // R9: tag flag stays up until the done cycle
    p_tag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tag_chk && !done |=> tag_chk);

    // R3: successive writes of one store keep the base parity
    p_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready |=> !wr_valid || (wr_addr[0] == $past(wr_addr[0])));
endmodule

bind pstore_seq pstore_seq_chk #(.AW(AW)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .done         (done),
    .sp_align_chk (sp_align_chk),
    .tag_chk      (tag_chk)
);

// File: tb/test_pstore_seq.sv
`timescale 1ns/1ps
module test_pstore_seq;
    localparam int BVL = 64;
    localparam int AW  = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [BVL-1:0] vec_in = '0;
    logic [7:0]     pred_in = '0;
    logic [AW-1:0]  base_in = '0;
    logic           base_sp = 1'b0;
    logic [3:0]     imm_in = '0;
    logic [1:0]     size_code = 2'b01;
    logic           empty_sp_chk = 1'b0;
    logic           wr_valid;
    logic           wr_ready = 1'b0;
    logic [AW-1:0]  wr_addr;
    logic [15:0]    wr_data;
    logic           done;
    logic           sp_align_chk;
    logic           tag_chk;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pstore_seq #(.VL(BVL), .AW(AW)) i_pstore_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_in(vec_in),
        .pred_in(pred_in), .base_in(base_in), .base_sp(base_sp),
        .imm_in(imm_in), .size_code(size_code), .empty_sp_chk(empty_sp_chk),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done), .sp_align_chk(sp_align_chk),
        .tag_chk(tag_chk)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] p, input logic [1:0] szc, input logic [3:0] im,
                          input logic [63:0] b, input logic bsp, input logic en, input int bp);
        logic [63:0] vv;
        logic [63:0] ea [4];
        logic [15:0] ed [4];
        int sh, esz, n, cnt, k, c;
        longint si;
        bit acc_prev, stall_prev, seen_done;
        logic [63:0] pa;
        logic [15:0] pd;
        vv = {$urandom, $urandom};
        sh  = (szc == 2'b11) ? 2 : (szc == 2'b10) ? 1 : 0;
        esz = 16 << sh;
        n   = BVL / esz;
        si  = im[3] ? longint'(im) - 16 : longint'(im);
        cnt = 0;
        for (int e = 0; e < n; e++) begin
            if (p[e*esz/8]) begin
                ea[cnt] = b + 64'((si * n + e) * 2);
                ed[cnt] = vv[e*esz +: 16];
                cnt++;
            end
        end
        @(negedge clk);
        start = 1'b1; vec_in = vv; pred_in = p; base_in = b; base_sp = bsp;
        imm_in = im; size_code = szc; empty_sp_chk = en;
        wr_ready = 1'b0;
        @(negedge clk);
        c = 1;
        // R8 and R9 at the first cycle after start
        chk(sp_align_chk == (bsp && (cnt > 0 || en)), "R8 align strobe", 64'(sp_align_chk), 64'(bsp && (cnt > 0 || en)));
        chk(tag_chk == !bsp, "R9 tag flag", 64'(tag_chk), 64'(!bsp));
        // R7: keep start high with altered inputs; must be ignored
        vec_in = ~vv; pred_in = ~p; base_in = ~b; imm_in = ~im;
        k = 0; acc_prev = 0; stall_prev = 0; seen_done = 0;
        pa = '0; pd = '0;
        while (c < 60) begin
            if (c == 2) start = 1'b0;
            if (done) begin
                seen_done = 1;
                chk(k == cnt, "R2 write count", 64'(k), 64'(cnt));
                chk((cnt == 0) ? (c == 1) : acc_prev, "R6 done timing", 64'(c), 64'(cnt));
                chk(!wr_valid, "R6 done excl", 64'(wr_valid), 64'd0);
                chk(tag_chk == !bsp, "R9 tag at done", 64'(tag_chk), 64'(!bsp));
                break;
            end
            if (wr_valid) begin
                if (stall_prev) begin
                    chk(wr_addr == pa && wr_data == pd, "R5 hold", wr_addr, pa);
                end
                if (k < cnt) begin
                    chk(wr_addr == ea[k], "R3 address", wr_addr, ea[k]);
                    chk(wr_data == ed[k], "R1 data", 64'(wr_data), 64'(ed[k]));
                end else begin
                    chk(1'b0, "R2 extra write", 64'(k), 64'(cnt));
                end
            end
            wr_ready = (bp == 0) ? 1'b1 : (((c + bp) % 3) != 0);
            acc_prev   = wr_valid && wr_ready;
            stall_prev = wr_valid && !wr_ready;
            pa = wr_addr; pd = wr_data;
            if (acc_prev) k++;
            @(negedge clk);
            c++;
        end
        if (!seen_done) chk(1'b0, "R6 done missing", 64'(c), 64'd0);
        @(negedge clk);
        start = 1'b0; wr_ready = 1'b0;
        chk(!wr_valid && !done && !tag_chk, "R7 idle after op", 64'({wr_valid, done, tag_chk}), 64'd0);
    endtask

    initial begin
        #2_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!wr_valid && !done && !sp_align_chk && !tag_chk, "R11 reset",
            64'({wr_valid, done, sp_align_chk, tag_chk}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_valid && !done && !sp_align_chk && !tag_chk, "R11 after reset",
            64'({wr_valid, done, sp_align_chk, tag_chk}), 64'd0);
        // R1 R2 R4: every predicate for each container size
        for (int sc = 1; sc < 4; sc++) begin
            for (int p = 0; p < 256; p++) begin
                run_op(8'(p), 2'(sc), 4'(p >> 4), {$urandom, $urandom},
                       (p % 7) == 0, p[0] ^ sc[0], p % 3);
            end
        end
        // R3: all immediates, full predicate
        for (int sc = 1; sc < 4; sc++) begin
            for (int im = 0; im < 16; im++) begin
                run_op(8'hFF, 2'(sc), 4'(im), 64'h1000, 1'b0, 1'b0, im % 3);
            end
        end
        // R8: empty predicate on stack-pointer base, both settings
        run_op(8'h00, 2'b01, 4'd0, 64'h40, 1'b1, 1'b0, 0);
        run_op(8'h00, 2'b11, 4'd3, 64'h40, 1'b1, 1'b1, 0);
        // R10: wrap at both ends
        run_op(8'hFF, 2'b01, 4'd7, 64'hFFFF_FFFF_FFFF_FFF8, 1'b0, 1'b0, 1);
        run_op(8'hFF, 2'b10, 4'd8, 64'h0000_0000_0000_0004, 1'b1, 1'b0, 2);
        // R1: code 00 behaves as halfword containers
        run_op(8'h5A, 2'b00, 4'd1, 64'h2000, 1'b0, 1'b0, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule